// File: doc/BRIEF.md
# Synchronous Receive Character Aligner

This block is the receive front end of a byte-oriented synchronous serial link. It runs on the receive bit clock and takes one data sample on each rising edge, one sample per bit. After reset the block is hunting: it looks for character alignment in the incoming bit stream. Three alignment methods are available and all three share the same datapath. The single-pattern method matches one 8-bit programmed pattern. The double-pattern method needs two programmed 8-bit patterns back to back. The external method takes the alignment decision from an active-low strobe driven by logic outside the block.

Once alignment is found, the block assembles characters of 5 to 8 bits, least significant bit first. It presents each character with a one-cycle valid strobe. Assembly stops, and the block goes back to hunting, on reset, when the receiver is disabled, or when the controlling logic requests a fresh hunt. The sync pin has two roles. In the internal modes it is an output that pulses when the pattern is recognised. In the external mode it is an input, and the block reports the pin direction through an output-enable.

Top module: `sync_rx_hunter`

## Requirements
- R1: When reset is released, `hunting` is 1, and both `char_valid` and `sync_out` are 0.
- R2: With `align_mode`=0, the stream is compared against `sync_b`, least significant bit first. In the cycle after the edge that samples the last matching bit, `hunting` is 0 and `sync_out` is 1. `sync_out` is 1 for exactly one cycle.
- R3: With `align_mode`=1, alignment needs the 8 bits of `sync_a` followed at once by the 8 bits of `sync_b`, each sent least significant bit first. `sync_b` on its own leaves `hunting` at 1.
- R4: `sync_oe` is 1 when `align_mode` is 0 or 1, and 0 when it is 2 or 3. `sync_out` is never 1 in modes 2 and 3.
- R5: The first character starts on the bit right after the last bit of the pattern. It holds N = 5 + `char_len` bits, first-received bit in bit 0. `char_valid` is 1 in the cycle after the edge that samples its last bit, and `char_data` then carries the character zero-extended to 8 bits.
- R6: With `align_mode` 2 or 3, a falling edge of `sync_n_in` ends the hunt. The falling edge is seen as high at one edge and low at the next. The bit sampled on the edge before the one that first sees the pin low becomes bit 0 of the first character.
- R7: While `rx_en` is 0 the block is hunting, detects no pattern and gives no `char_valid`. Dropping `rx_en` during assembly returns `hunting` to 1 in the next cycle.
- R8: When `hunt_req` is 1 at an edge, `hunting` is 1 after that edge. No `char_valid` follows until alignment is found again.
- R9: The stream pattern has no effect in the external modes, and `sync_n_in` has no effect in the internal modes.
- R10: `char_valid` never stays high for two cycles. Characters follow one another without gaps, one every N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one data sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial receive data |
| rx_en | input | 1 | Receiver enable |
| hunt_req | input | 1 | Request to abandon alignment and hunt again |
| align_mode | input | 2 | 0 single pattern, 1 double pattern, 2 or 3 external strobe |
| char_len | input | 2 | Character length minus 5 |
| sync_a | input | 8 | First pattern of the double-pattern method |
| sync_b | input | 8 | Single pattern, or second pattern of the double-pattern method |
| sync_n_in | input | 1 | Active-low external alignment strobe |
| sync_out | output | 1 | Pattern-detected pulse in the internal modes |
| sync_oe | output | 1 | Sync pin drive enable, 1 when `sync_out` is meaningful |
| char_data | output | 8 | Assembled character |
| char_valid | output | 1 | One-cycle strobe for `char_data` |
| hunting | output | 1 | 1 while the receiver is searching for alignment |

## Verification
The hardest situation to reach is the external-strobe start. There, the first character bit has already gone past one edge before the block learns that alignment exists. The stimulus puts a known bit on the line while the strobe is still high and lowers the strobe together with the second bit. It then checks that the assembled character contains that earlier bit as bit 0, for every character length. A second hard case is a false match made from the idle fill and the first pattern bits. The bench picks patterns whose first two bits are 0 then 1 and idles with zeros, so no shifted window can match early. It also sends the second pattern on its own in double mode to show that half a pattern is not enough.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    localparam int SYNC_W   = 8;
    localparam int WIN_W    = 2 * SYNC_W;
    localparam int CHAR_MAX = 8;
    localparam int LEN_W    = 2;
    localparam int LEN_MIN  = 5;
    localparam int CNT_W    = $clog2(CHAR_MAX + 1);
    localparam int FILL_W   = $clog2(WIN_W + 1);

    typedef enum logic [1:0] {
        ALIGN_SINGLE  = 2'd0,
        ALIGN_DOUBLE  = 2'd1,
        ALIGN_EXT     = 2'd2,
        ALIGN_EXT_ALT = 2'd3
    } align_mode_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_DATA = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic                single_hit;
        logic                double_hit;
        logic                ext_hit;
    } hit_t;

    typedef struct packed {
        logic                valid;
        logic [CHAR_MAX-1:0] data;
    } char_out_t;

    function automatic logic [CNT_W-1:0] char_bits(input logic [LEN_W-1:0] sel);
        return CNT_W'(LEN_MIN) + CNT_W'(sel);
    endfunction

    function automatic logic is_internal(input align_mode_e m);
        return (m == ALIGN_SINGLE) || (m == ALIGN_DOUBLE);
    endfunction

endpackage

// File: rtl/rx_shift_window.sv
module rx_shift_window
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              bit_in,
    output logic [WIN_W-1:0]  win_next,
    output logic [FILL_W-1:0] depth_next,
    output logic              prev_bit
);

    logic [WIN_W-1:0]  win_q;
    logic [FILL_W-1:0] fill_q;

    // newest bit enters at the top; oldest leaves at bit 0
    assign win_next   = {bit_in, win_q[WIN_W-1:1]};
    assign depth_next = !en ? '0 :
                        (fill_q == FILL_W'(WIN_W)) ? fill_q : fill_q + FILL_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            fill_q   <= '0;
            prev_bit <= 1'b0;
        end else begin
            prev_bit <= bit_in;
            fill_q   <= depth_next;
            if (en) begin
                win_q <= win_next;
            end
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FILL_W'(WIN_W)) else $error("window fill overrun"); // R3

endmodule

// File: rtl/sync_matcher.sv
module sync_matcher
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  align_mode_e       mode,
    input  logic [WIN_W-1:0]  win_next,
    input  logic [FILL_W-1:0] depth_next,
    input  logic [SYNC_W-1:0] sync_a,
    input  logic [SYNC_W-1:0] sync_b,
    input  logic              sync_n_in,
    output hit_t              hits,
    output logic              found
);

    localparam int NSEG = WIN_W / SYNC_W;

    logic [NSEG-1:0] seg_eq;
    logic            sync_n_q;

    // segment 0 holds the older byte, the last segment the newest byte
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [SYNC_W-1:0] ref_pat;
        assign ref_pat   = (g == NSEG - 1) ? sync_b : sync_a;
        assign seg_eq[g] = (win_next[g*SYNC_W +: SYNC_W] == ref_pat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_n_q <= 1'b1;
        end else begin
            sync_n_q <= sync_n_in;
        end
    end

    always_comb begin
        hits.single_hit = seg_eq[NSEG-1] && (depth_next >= FILL_W'(SYNC_W));
        hits.double_hit = (&seg_eq) && (depth_next >= FILL_W'(WIN_W));
        hits.ext_hit    = sync_n_q && !sync_n_in;
        unique case (mode)
            ALIGN_SINGLE: found = hits.single_hit;
            ALIGN_DOUBLE: found = hits.double_hit;
            default:      found = hits.ext_hit;
        endcase
    end

    AST_DOUBLE_IMPLIES_B: assert property (@(posedge clk) disable iff (rst)
        hits.double_hit |-> (win_next[WIN_W-1 -: SYNC_W] == sync_b)) else $error("double hit without second pattern"); // R3

endmodule

// File: rtl/hunt_ctrl.sv
module hunt_ctrl
    import sync_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic        hunt_req,
    input  align_mode_e mode,
    input  logic        found,
    output rx_state_e   state,
    output logic        start,
    output logic        ext_start,
    output logic        active,
    output logic        sync_pulse
);

    assign start     = rx_en && !hunt_req && (state == ST_HUNT) && found;
    assign ext_start = start && !is_internal(mode);
    assign active    = rx_en && !hunt_req && (state == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HUNT;
            sync_pulse <= 1'b0;
        end else begin
            sync_pulse <= 1'b0;
            if (!rx_en || hunt_req) begin
                state <= ST_HUNT;
            end else if (start) begin
                state      <= ST_DATA;
                sync_pulse <= is_internal(mode);
            end
        end
    end

    AST_OFF_MEANS_HUNT: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (state == ST_HUNT)) else $error("aligned while disabled"); // R7

    AST_REQ_MEANS_HUNT: assert property (@(posedge clk) disable iff (rst)
        hunt_req |=> (state == ST_HUNT)) else $error("hunt request ignored"); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse) else $error("sync pulse too long"); // R2

    AST_PULSE_LEAVES_HUNT: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> (state == ST_DATA)) else $error("sync pulse while hunting"); // R2

endmodule

// File: rtl/char_assembler.sv
module char_assembler
    import sync_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ext_start,
    input  logic             active,
    input  logic             bit_in,
    input  logic             prev_bit,
    input  logic [LEN_W-1:0] len_sel,
    output char_out_t        char_out
);

    logic [CHAR_MAX-1:0] shreg;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    nbits;
    logic [CNT_W-1:0]    pad;
    logic [CHAR_MAX-1:0] shreg_nxt;
    logic                last_bit;

    assign nbits     = char_bits(len_sel);
    assign pad       = CNT_W'(CHAR_MAX) - nbits;
    assign shreg_nxt = {bit_in, shreg[CHAR_MAX-1:1]};
    assign last_bit  = (cnt + CNT_W'(1)) >= nbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            cnt      <= '0;
            char_out <= '0;
        end else begin
            char_out.valid <= 1'b0;
            if (start) begin
                if (ext_start) begin
                    // bit before the strobe edge is bit 0, this edge's bit is bit 1
                    shreg <= {bit_in, prev_bit, shreg[CHAR_MAX-1:2]};
                    cnt   <= CNT_W'(2);
                end else begin
                    cnt <= '0;
                end
            end else if (active) begin
                if (last_bit) begin
                    char_out.valid <= 1'b1;
                    char_out.data  <= shreg_nxt >> pad;
                    cnt            <= '0;
                end else begin
                    shreg <= shreg_nxt;
                    cnt   <= cnt + CNT_W'(1);
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        char_out.valid |=> !char_out.valid) else $error("valid held two cycles"); // R10

    AST_VALID_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        char_out.valid |-> $past(active)) else $error("character outside assembly"); // R7

endmodule

// File: rtl/sync_rx_hunter.sv
module sync_rx_hunter
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    input  logic              rx_en,
    input  logic              hunt_req,
    input  logic [1:0]        align_mode,
    input  logic [LEN_W-1:0]  char_len,
    input  logic [SYNC_W-1:0] sync_a,
    input  logic [SYNC_W-1:0] sync_b,
    input  logic              sync_n_in,
    output logic              sync_out,
    output logic              sync_oe,
    output logic [CHAR_MAX-1:0] char_data,
    output logic              char_valid,
    output logic              hunting
);

    align_mode_e       mode;
    logic [WIN_W-1:0]  win_next;
    logic [FILL_W-1:0] depth_next;
    logic              prev_bit;
    hit_t              hits;
    logic              found;
    rx_state_e         state;
    logic              start;
    logic              ext_start;
    logic              active;
    logic              sync_pulse;
    char_out_t         char_out;

    assign mode = align_mode_e'(align_mode);

    rx_shift_window u_window (
        .clk        (clk),
        .rst        (rst),
        .en         (rx_en),
        .bit_in     (rx_bit),
        .win_next   (win_next),
        .depth_next (depth_next),
        .prev_bit   (prev_bit)
    );

    sync_matcher u_match (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .win_next   (win_next),
        .depth_next (depth_next),
        .sync_a     (sync_a),
        .sync_b     (sync_b),
        .sync_n_in  (sync_n_in),
        .hits       (hits),
        .found      (found)
    );

    hunt_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .hunt_req   (hunt_req),
        .mode       (mode),
        .found      (found),
        .state      (state),
        .start      (start),
        .ext_start  (ext_start),
        .active     (active),
        .sync_pulse (sync_pulse)
    );

    char_assembler u_asm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ext_start  (ext_start),
        .active     (active),
        .bit_in     (rx_bit),
        .prev_bit   (prev_bit),
        .len_sel    (char_len),
        .char_out   (char_out)
    );

    assign sync_oe    = is_internal(mode);
    assign sync_out   = sync_pulse;
    assign char_data  = char_out.data;
    assign char_valid = char_out.valid;
    assign hunting    = (state == ST_HUNT);

    AST_EXT_SILENT: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> $past(sync_oe)) else $error("sync pulse in external mode"); // R4

    AST_PULSE_NOT_HUNTING: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> !hunting) else $error("pulse while hunting"); // R2

    AST_NO_CHAR_WHILE_HUNT: assert property (@(posedge clk) disable iff (rst)
        (hunting && $past(hunting)) |-> !char_valid) else $error("character while hunting"); // R8

endmodule

// File: tb/sync_rx_hunter_bench.sv
module sync_rx_hunter_bench;

    logic       clk = 1'b0;
    logic       rst, rx_bit, rx_en, hunt_req, sync_n_in;
    logic [1:0] align_mode, char_len;
    logic [7:0] sync_a, sync_b;
    logic       sync_out, sync_oe, char_valid, hunting;
    logic [7:0] char_data;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sync_rx_hunter u_sync_rx_hunter (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_en(rx_en), .hunt_req(hunt_req),
        .align_mode(align_mode), .char_len(char_len), .sync_a(sync_a), .sync_b(sync_b),
        .sync_n_in(sync_n_in), .sync_out(sync_out), .sync_oe(sync_oe),
        .char_data(char_data), .char_valid(char_valid), .hunting(hunting)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic b);
        rx_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; rx_en = 1'b0; hunt_req = 1'b0; sync_n_in = 1'b1; rx_bit = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic idle_zeros(input int k, input string req);
        for (int i = 0; i < k; i++) begin
            step(1'b0);
            check(hunting == 1'b1 && char_valid == 1'b0 && sync_out == 1'b0, req,
                  {hunting, char_valid, sync_out}, 3'b100);
        end
    endtask

    // sends the pattern and checks the hunt ends on its last bit
    task automatic send_sync(input logic [1:0] m, input string req);
        if (m == 2'd1) begin
            for (int i = 0; i < 8; i++) begin
                step(sync_a[i]);
                check(hunting == 1'b1, req, hunting, 1);
            end
        end
        for (int i = 0; i < 8; i++) begin
            step(sync_b[i]);
            if (i < 7) check(hunting == 1'b1, req, hunting, 1);
            else       check(hunting == 1'b0 && sync_out == 1'b1, req, {hunting, sync_out}, 2'b01);
        end
    endtask

    task automatic send_char(input logic [7:0] v, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step(v[i]);
            if (i < n - 1) begin
                check(char_valid == 1'b0, req, char_valid, 0);
            end else begin
                check(char_valid == 1'b1, req, char_valid, 1);
                check(char_data == (v & 8'((1 << n) - 1)), req, char_data, v & 8'((1 << n) - 1));
            end
        end
    endtask

    initial begin
        logic [7:0] pats [3];
        logic [7:0] v;
        int n;
        pats[0] = 8'h96; pats[1] = 8'h6A; pats[2] = 8'h2E;
        align_mode = 2'd0; char_len = 2'd3; sync_a = 8'h3A; sync_b = 8'h96;

        do_reset();
        check(hunting == 1'b1 && char_valid == 1'b0 && sync_out == 1'b0, "R1 reset state",
              {hunting, char_valid, sync_out}, 3'b100);

        for (int m = 0; m < 4; m++) begin
            align_mode = 2'(m);
            #1;
            check(sync_oe == (m < 2), "R4 sync_oe", sync_oe, (m < 2));
        end

        // sweep internal modes, lengths and patterns
        for (int m = 0; m < 2; m++) begin
            for (int len = 0; len < 4; len++) begin
                for (int s = 0; s < 3; s++) begin
                    align_mode = 2'(m); char_len = 2'(len); sync_b = pats[s]; sync_a = 8'h3A;
                    n = 5 + len;
                    do_reset();
                    rx_en = 1'b1;
                    idle_zeros(10, "R2 idle hunt");
                    send_sync(2'(m), m ? "R3 double sync" : "R2 single sync");
                    for (int c = 0; c < 3; c++) begin
                        v = 8'((s * 37 + c * 91 + len * 5 + m * 3 + 7) & 8'hFF);
                        send_char(v, n, "R5 R10 character");
                        if (c == 0) check(sync_out == 1'b0, "R2 pulse width", sync_out, 0);
                    end
                end
            end
        end

        // R3: second pattern alone in double mode
        align_mode = 2'd1; char_len = 2'd3; sync_a = 8'h3A; sync_b = 8'h96;
        do_reset(); rx_en = 1'b1;
        idle_zeros(6, "R3 lead");
        for (int i = 0; i < 8; i++) begin
            step(sync_b[i]);
            check(hunting == 1'b1 && sync_out == 1'b0, "R3 half pattern", hunting, 1);
        end
        idle_zeros(16, "R3 tail");

        // R6 / R9: external strobe
        for (int len = 0; len < 4; len++) begin
            align_mode = (len[0]) ? 2'd3 : 2'd2; char_len = 2'(len); sync_b = 8'h96;
            n = 5 + len;
            do_reset(); rx_en = 1'b1;
            idle_zeros(4, "R9 ext lead");
            for (int i = 0; i < 8; i++) begin
                step(sync_b[i]);
                check(hunting == 1'b1 && sync_out == 1'b0, "R9 pattern ignored in external mode",
                      hunting, 1);
            end
            v = 8'(8'hA5 ^ (len * 8'h1B));
            step(v[0]);
            check(hunting == 1'b1, "R6 before strobe", hunting, 1);
            sync_n_in = 1'b0;
            step(v[1]);
            check(hunting == 1'b0 && sync_out == 1'b0, "R6 strobe aligns, R4 no pulse",
                  {hunting, sync_out}, 2'b00);
            for (int i = 2; i < n; i++) begin
                step(v[i]);
                if (i < n - 1) check(char_valid == 1'b0, "R6 assembling", char_valid, 0);
            end
            check(char_valid == 1'b1 && char_data == (v & 8'((1 << n) - 1)), "R6 first char",
                  char_data, v & 8'((1 << n) - 1));
            send_char(8'h5C, n, "R6 R10 second char");
            sync_n_in = 1'b1;
        end

        // R9: strobe ignored in internal mode
        align_mode = 2'd0; char_len = 2'd3; sync_b = 8'h96;
        do_reset(); rx_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            sync_n_in = i[0];
            step(1'b0);
            check(hunting == 1'b1 && char_valid == 1'b0, "R9 strobe ignored in internal mode",
                  hunting, 1);
        end
        sync_n_in = 1'b1;

        // R7: disabled receiver
        do_reset();
        rx_en = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b0);
        for (int i = 0; i < 8; i++) begin
            step(sync_b[i]);
            check(hunting == 1'b1 && sync_out == 1'b0, "R7 no hunt while disabled",
                  {hunting, sync_out}, 2'b10);
        end
        rx_en = 1'b1;
        idle_zeros(4, "R7 lead");
        send_sync(2'd0, "R7 sync");
        for (int i = 0; i < 3; i++) step(1'b1);
        rx_en = 1'b0;
        step(1'b1);
        check(hunting == 1'b1, "R7 disable returns to hunt", hunting, 1);
        for (int i = 0; i < 10; i++) begin
            step(1'b1);
            check(char_valid == 1'b0 && hunting == 1'b1, "R7 no characters", char_valid, 0);
        end

        // R8: enter-hunt request
        rx_en = 1'b1;
        idle_zeros(4, "R8 lead");
        send_sync(2'd0, "R8 sync");
        for (int i = 0; i < 3; i++) step(1'b1);
        hunt_req = 1'b1;
        step(1'b1);
        hunt_req = 1'b0;
        check(hunting == 1'b1, "R8 request returns to hunt", hunting, 1);
        idle_zeros(12, "R8 no characters after request");
        send_sync(2'd0, "R8 realign");
        send_char(8'hC3, 8, "R8 R5 char after realign");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule